// File: doc/BRIEF.md
# NAND Flash Command Front End

This block sits at the device end of a small NAND-style flash interface. An external host drives an 8-bit shared I/O bus along with a chip-enable strobe, a write strobe, a command-latch strobe and an address-latch strobe. The block runs on its own clock and samples these pins. Each time the write strobe rises while chip enable is asserted, the block takes one bus cycle and sorts it as a command byte, an address byte or a data byte.

The decoder follows the one-cycle commands, and the two-cycle setup/confirm pairs for frame program and block erase. It builds the 19-bit byte address from the address cycles. It then issues a single one-clock operation strobe to the back end, with the assembled address held beside it. Data bytes written during a program sequence go to a page-buffer write port, starting at the column address.

While the back end reports busy, the block filters its input. Only the reset command and the status command get through.

Top module: `nand_cmd_front`

## Requirements
- R1: A bus cycle is captured only when the write strobe rises (low to high) while chip enable is low. A rising write strobe with chip enable high has no effect.
- R2: A captured cycle is a command when the command latch input is high and an address byte when the address latch input is high. It is a data byte when both are low. A cycle with both latch inputs high is discarded.
- R3: Codes 70h, 90h and FFh each raise their own strobe (status, identify, reset) for one clock, in the clock after capture. Any other unknown command code abandons the sequence in progress and raises no strobe.
- R4: Command 00h followed by three address cycles raises the read strobe on the third cycle. The address is {third[2:0], second, first}, and bits 7:3 of the third address byte are ignored.
- R5: Command 80h, then three address cycles, then confirm 10h raises the program strobe with the address formed as in R4.
- R6: Command 60h, then two row address cycles, then confirm D0h raises the erase strobe. The address is {second[2:0], first[7:4], 12'h000}, which selects one of 128 blocks of 4 KB.
- R7: A confirm code is dropped without a strobe if it arrives without its setup code, after too few address cycles, or after the other operation's setup.
- R8: While busy is high, only FFh and 70h take effect. All other commands, address bytes and data bytes are ignored and leave the sequence state unchanged.
- R9: Command FFh abandons any partly entered sequence. From the next clock on, the decoder is idle: following data is discarded and a following confirm is dropped.
- R10: Each data byte written after the third address cycle of a program sequence raises the page-buffer write for one clock. The pointer is the column address plus the number of bytes already written, wrapping modulo 256. Data bytes written at any other time are discarded.
- R11: After reset all outputs are zero. At most one operation strobe is high in any clock, and the operation address changes only together with a read, program or erase strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, byte taken on its rising edge |
| cle | input | 1 | Command latch select |
| ale | input | 1 | Address latch select |
| io_bus | input | 8 | Shared command/address/data bus |
| busy | input | 1 | Back end busy flag |
| op_read | output | 1 | Read operation strobe |
| op_program | output | 1 | Frame program strobe |
| op_erase | output | 1 | Block erase strobe |
| op_status | output | 1 | Status read strobe |
| op_id | output | 1 | Identify strobe |
| op_reset | output | 1 | Reset strobe |
| op_addr | output | 19 | Byte address for the read, program and erase strobes |
| pbuf_we | output | 1 | Page-buffer write strobe |
| pbuf_ptr | output | 8 | Page-buffer write pointer |
| pbuf_data | output | 8 | Page-buffer write data |

## Verification
The bench sends confirm codes out of place: with no setup, after two address bytes, and after the other operation's setup. A decoder that only matched confirm codes would raise a program or erase strobe on any of these. It writes program data starting at column FEh, where a pointer that failed to wrap would point past the page. It interleaves busy with setup, address and data cycles. A filter that blocked only commands would let data into the buffer or move the address count on. It also sends a reset in the middle of a program sequence and a third address byte with its upper bits set, which catch leftover sequence state and address bits that should have been masked.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
    localparam int IO_W        = 8;
    localparam int ROW_HI_W    = 3;
    localparam int COL_W       = IO_W;
    localparam int ROW_W       = IO_W + ROW_HI_W;
    localparam int ADDR_W      = COL_W + ROW_W;
    localparam int BLK_LSB     = 12;
    localparam int RW_ADDR_CYC = 3;
    localparam int ER_ADDR_CYC = 2;
    localparam int CNT_W       = $clog2(RW_ADDR_CYC + 1);

    localparam logic [IO_W-1:0] CMD_READ     = 8'h00;
    localparam logic [IO_W-1:0] CMD_RESET    = 8'hFF;
    localparam logic [IO_W-1:0] CMD_STATUS   = 8'h70;
    localparam logic [IO_W-1:0] CMD_ID       = 8'h90;
    localparam logic [IO_W-1:0] CMD_PG_SETUP = 8'h80;
    localparam logic [IO_W-1:0] CMD_PG_CONF  = 8'h10;
    localparam logic [IO_W-1:0] CMD_ER_SETUP = 8'h60;
    localparam logic [IO_W-1:0] CMD_ER_CONF  = 8'hD0;

    typedef enum logic [1:0] {CYC_CMD, CYC_ADDR, CYC_DATA} cyc_kind_e;

    typedef struct packed {
        logic            valid;
        cyc_kind_e       kind;
        logic [IO_W-1:0] val;
    } bus_cyc_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_ADDR, ST_PG_ADDR, ST_PG_DATA, ST_ER_ADDR, ST_ER_CONF
    } seq_st_e;

    typedef struct packed {
        logic rd;
        logic pg;
        logic er;
        logic st;
        logic id;
        logic rs;
    } op_vec_t;

    function automatic logic busy_pass(input logic [IO_W-1:0] code);
        return (code == CMD_RESET) || (code == CMD_STATUS);
    endfunction

    function automatic logic [ADDR_W-1:0] erase_base(input logic [ROW_W-1:0] row);
        logic [ADDR_W-1:0] a;
        a = {row, {COL_W{1'b0}}};
        a[BLK_LSB-1:0] = '0;
        return a;
    endfunction
endpackage

// File: rtl/nfc_bus_capture.sv
module nfc_bus_capture
    import nfc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ce_n,
    input  logic            we_n,
    input  logic            cle,
    input  logic            ale,
    input  logic [IO_W-1:0] io_bus,
    output bus_cyc_t        cyc
);
    logic we_q;

    always_ff @(posedge clk) begin
        if (rst) we_q <= 1'b1;
        else     we_q <= we_n;
    end

    always_comb begin
        cyc.valid = !we_q && we_n && !ce_n && !(cle && ale);
        cyc.val   = io_bus;
        if (cle)      cyc.kind = CYC_CMD;
        else if (ale) cyc.kind = CYC_ADDR;
        else          cyc.kind = CYC_DATA;
    end
endmodule

// File: rtl/nfc_seq_ctrl.sv
module nfc_seq_ctrl
    import nfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  bus_cyc_t          cyc,
    output op_vec_t           ops,
    output logic [ADDR_W-1:0] op_addr,
    output logic              pg_phase,
    output logic [COL_W-1:0]  col
);
    seq_st_e             st, st_n;
    logic [CNT_W-1:0]    acnt, acnt_n;
    logic [COL_W-1:0]    col_r, col_n;
    logic [IO_W-1:0]     lo_r, lo_n;
    logic [ROW_HI_W-1:0] hi_r, hi_n;
    op_vec_t             ops_n;
    logic [ADDR_W-1:0]   addr_n;
    logic                take;

    always_comb begin
        st_n   = st;
        acnt_n = acnt;
        col_n  = col_r;
        lo_n   = lo_r;
        hi_n   = hi_r;
        ops_n  = '0;
        addr_n = op_addr;
        take   = cyc.valid && (!busy || (cyc.kind == CYC_CMD && busy_pass(cyc.val)));
        if (take && cyc.kind == CYC_CMD) begin
            st_n   = ST_IDLE;
            acnt_n = '0;
            case (cyc.val)
                CMD_RESET:    ops_n.rs = 1'b1;
                CMD_STATUS:   ops_n.st = 1'b1;
                CMD_ID:       ops_n.id = 1'b1;
                CMD_READ:     st_n = ST_RD_ADDR;
                CMD_PG_SETUP: st_n = ST_PG_ADDR;
                CMD_ER_SETUP: st_n = ST_ER_ADDR;
                CMD_PG_CONF: begin
                    if (st == ST_PG_DATA) begin
                        ops_n.pg = 1'b1;
                        addr_n   = {hi_r, lo_r, col_r};
                    end
                end
                CMD_ER_CONF: begin
                    if (st == ST_ER_CONF) begin
                        ops_n.er = 1'b1;
                        addr_n   = erase_base({hi_r, lo_r});
                    end
                end
                default: ;
            endcase
        end else if (take && cyc.kind == CYC_ADDR) begin
            case (st)
                ST_RD_ADDR, ST_PG_ADDR: begin
                    if (acnt == CNT_W'(0))      col_n = cyc.val;
                    else if (acnt == CNT_W'(1)) lo_n  = cyc.val;
                    else                        hi_n  = cyc.val[ROW_HI_W-1:0];
                    acnt_n = acnt + CNT_W'(1);
                    if (acnt == CNT_W'(RW_ADDR_CYC - 1)) begin
                        acnt_n = '0;
                        if (st == ST_RD_ADDR) begin
                            ops_n.rd = 1'b1;
                            st_n     = ST_IDLE;
                            addr_n   = {hi_n, lo_n, col_n};
                        end else begin
                            st_n = ST_PG_DATA;
                        end
                    end
                end
                ST_ER_ADDR: begin
                    if (acnt == CNT_W'(0)) lo_n = cyc.val;
                    else                   hi_n = cyc.val[ROW_HI_W-1:0];
                    acnt_n = acnt + CNT_W'(1);
                    if (acnt == CNT_W'(ER_ADDR_CYC - 1)) begin
                        acnt_n = '0;
                        st_n   = ST_ER_CONF;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            acnt    <= '0;
            col_r   <= '0;
            lo_r    <= '0;
            hi_r    <= '0;
            ops     <= '0;
            op_addr <= '0;
        end else begin
            st      <= st_n;
            acnt    <= acnt_n;
            col_r   <= col_n;
            lo_r    <= lo_n;
            hi_r    <= hi_n;
            ops     <= ops_n;
            op_addr <= addr_n;
        end
    end

    assign pg_phase = (st == ST_PG_DATA);
    assign col      = col_r;
endmodule

// File: rtl/nfc_page_wr.sv
module nfc_page_wr
    import nfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  bus_cyc_t         cyc,
    input  logic             pg_phase,
    input  logic [COL_W-1:0] col,
    output logic             pb_we,
    output logic [COL_W-1:0] pb_ptr,
    output logic [IO_W-1:0]  pb_data
);
    logic [COL_W-1:0] offs;
    logic             hit;

    assign hit = cyc.valid && (cyc.kind == CYC_DATA) && pg_phase && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            offs    <= '0;
            pb_we   <= 1'b0;
            pb_ptr  <= '0;
            pb_data <= '0;
        end else begin
            pb_we <= hit;
            if (!pg_phase) offs <= '0;
            if (hit) begin
                pb_ptr  <= col + offs;
                pb_data <= cyc.val;
                offs    <= offs + COL_W'(1);
            end
        end
    end
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              cle,
    input  logic              ale,
    input  logic [IO_W-1:0]   io_bus,
    input  logic              busy,
    output logic              op_read,
    output logic              op_program,
    output logic              op_erase,
    output logic              op_status,
    output logic              op_id,
    output logic              op_reset,
    output logic [ADDR_W-1:0] op_addr,
    output logic              pbuf_we,
    output logic [COL_W-1:0]  pbuf_ptr,
    output logic [IO_W-1:0]   pbuf_data
);
    bus_cyc_t         cyc;
    op_vec_t          ops;
    logic             pg_phase;
    logic [COL_W-1:0] col;

    nfc_bus_capture i_cap (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n),
        .cle(cle), .ale(ale), .io_bus(io_bus), .cyc(cyc)
    );

    nfc_seq_ctrl i_seq (
        .clk(clk), .rst(rst), .busy(busy), .cyc(cyc), .ops(ops),
        .op_addr(op_addr), .pg_phase(pg_phase), .col(col)
    );

    nfc_page_wr i_pwr (
        .clk(clk), .rst(rst), .busy(busy), .cyc(cyc), .pg_phase(pg_phase),
        .col(col), .pb_we(pbuf_we), .pb_ptr(pbuf_ptr), .pb_data(pbuf_data)
    );

    assign op_read    = ops.rd;
    assign op_program = ops.pg;
    assign op_erase   = ops.er;
    assign op_status  = ops.st;
    assign op_id      = ops.id;
    assign op_reset   = ops.rs;
endmodule

// File: rtl/nfc_front_chk.sv
module nfc_front_chk
    import nfc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              we_n,
    input logic              cle,
    input logic              ale,
    input logic              busy,
    input logic              op_read,
    input logic              op_program,
    input logic              op_erase,
    input logic              op_status,
    input logic              op_id,
    input logic              op_reset,
    input logic [ADDR_W-1:0] op_addr,
    input logic              pbuf_we
);
    logic any_op;
    assign any_op = op_read | op_program | op_erase | op_status | op_id | op_reset;

    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({op_read, op_program, op_erase, op_status, op_id, op_reset}));

    a_r11_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !(op_read || op_program || op_erase) |-> $stable(op_addr));

    a_r1_after_we_rise: assert property (@(posedge clk) disable iff (rst)
        (any_op || pbuf_we) |-> ($past(we_n) && !$past(we_n, 2) && !$past(ce_n)));

    a_r8_busy_filter: assert property (@(posedge clk) disable iff (rst)
        (op_read || op_program || op_erase || op_id || pbuf_we) |-> !$past(busy));

    a_r6_erase_aligned: assert property (@(posedge clk) disable iff (rst)
        op_erase |-> (op_addr[BLK_LSB-1:0] == '0));

    a_r10_data_cycle: assert property (@(posedge clk) disable iff (rst)
        pbuf_we |-> (!$past(cle) && !$past(ale)));

    a_r2_cmd_cycle: assert property (@(posedge clk) disable iff (rst)
        (op_status || op_id || op_reset || op_program || op_erase) |-> ($past(cle) && !$past(ale)));
endmodule

bind nand_cmd_front nfc_front_chk i_chk (.*);

// File: tb/test_nand_cmd_front.sv
module test_nand_cmd_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, cle = 1'b0, ale = 1'b0, busy = 1'b0;
    logic [7:0]  io_bus = 8'h00;
    logic        op_read, op_program, op_erase, op_status, op_id, op_reset;
    logic [18:0] op_addr;
    logic        pbuf_we;
    logic [7:0]  pbuf_ptr, pbuf_data;

    nand_cmd_front i_nand_cmd_front (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
        .io_bus(io_bus), .busy(busy), .op_read(op_read), .op_program(op_program),
        .op_erase(op_erase), .op_status(op_status), .op_id(op_id), .op_reset(op_reset),
        .op_addr(op_addr), .pbuf_we(pbuf_we), .pbuf_ptr(pbuf_ptr), .pbuf_data(pbuf_data)
    );

    always #5 clk = ~clk;

    int    n_vec = 0, n_bad = 0;
    bit    done = 0;
    string req = "R11";

    // expected outputs
    bit          e_rd, e_pg, e_er, e_st, e_id, e_rs, e_we;
    logic [18:0] e_addr = '0;
    logic [7:0]  e_ptr, e_data;

    // behavioural model state: 0 idle, 1 read addr, 2 prog addr, 3 prog data, 4 erase addr, 5 erase confirm
    int          mode = 0;
    int          npg = 0;
    logic [7:0]  aq[$];

    localparam int K_DATA = 0, K_CMD = 1, K_ADDR = 2, K_BOTH = 3;

    task automatic tick();
        @(negedge clk);
        n_vec++;
        if ({op_read, op_program, op_erase, op_status, op_id, op_reset} !== {e_rd, e_pg, e_er, e_st, e_id, e_rs}
            || op_addr !== e_addr || pbuf_we !== e_we
            || (e_we && (pbuf_ptr !== e_ptr || pbuf_data !== e_data))) begin
            n_bad++;
            $display("FAIL %s: rd/pg/er/st/id/rs=%b addr=%h we=%b ptr=%h data=%h, expected %b addr=%h we=%b ptr=%h data=%h",
                     req, {op_read, op_program, op_erase, op_status, op_id, op_reset}, op_addr, pbuf_we, pbuf_ptr, pbuf_data,
                     {e_rd, e_pg, e_er, e_st, e_id, e_rs}, e_addr, e_we, e_ptr, e_data);
        end
        {e_rd, e_pg, e_er, e_st, e_id, e_rs, e_we} = '0;
    endtask

    task automatic model(input int k, input logic [7:0] b, input bit off);
        int prev;
        if (off || k == K_BOTH) return;
        if (busy && !(k == K_CMD && (b == 8'hFF || b == 8'h70))) return;
        if (k == K_CMD) begin
            prev = mode;
            mode = 0;
            if (b == 8'hFF) e_rs = 1;
            else if (b == 8'h70) e_st = 1;
            else if (b == 8'h90) e_id = 1;
            else if (b == 8'h00) begin mode = 1; aq.delete(); end
            else if (b == 8'h80) begin mode = 2; aq.delete(); end
            else if (b == 8'h60) begin mode = 4; aq.delete(); end
            else if (b == 8'h10 && prev == 3) begin
                e_pg = 1; e_addr = {aq[2][2:0], aq[1], aq[0]};
            end else if (b == 8'hD0 && prev == 5) begin
                e_er = 1; e_addr = {aq[1][2:0], aq[0][7:4], 12'h000};
            end
        end else if (k == K_ADDR) begin
            if (mode == 1 || mode == 2 || mode == 4) aq.push_back(b);
            if (mode == 1 && aq.size() == 3) begin
                e_rd = 1; e_addr = {aq[2][2:0], aq[1], aq[0]}; mode = 0;
            end else if (mode == 2 && aq.size() == 3) begin
                mode = 3; npg = 0;
            end else if (mode == 4 && aq.size() == 2) begin
                mode = 5;
            end
        end else if (mode == 3) begin
            e_we = 1; e_ptr = aq[0] + 8'(npg); e_data = b; npg++;
        end
    endtask

    task automatic wr(input int k, input logic [7:0] b, input bit off = 0);
        ce_n = off; cle = (k == K_CMD || k == K_BOTH); ale = (k == K_ADDR || k == K_BOTH);
        io_bus = b; we_n = 0;
        tick();
        we_n = 1;
        model(k, b, off);
        tick();
        ce_n = 1; cle = 0; ale = 0;
    endtask

    task automatic cmd(input logic [7:0] b); wr(K_CMD, b); endtask
    task automatic adr(input logic [7:0] b); wr(K_ADDR, b); endtask
    task automatic dat(input logic [7:0] b); wr(K_DATA, b); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        req = "R11"; tick(); tick();                 // reset state all zero

        req = "R3";  cmd(8'h70); cmd(8'h90); cmd(8'hFF);
        req = "R3";  cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03);
        cmd(8'h33); dat(8'hEE); cmd(8'h10);          // unknown code aborts program

        req = "R1";  wr(K_CMD, 8'h70, 1); wr(K_CMD, 8'hFF, 1);
        req = "R2";  wr(K_BOTH, 8'h70); adr(8'h12);
        req = "R10"; dat(8'h44);                      // data outside a program is dropped

        req = "R4";  cmd(8'h00); adr(8'h34); adr(8'h12); adr(8'hFD);
        for (int i = 0; i < 8; i++) begin
            cmd(8'h00); adr(8'(i * 37)); adr(8'(255 - i * 19)); adr(8'(i * 3 + 8'hF8));
        end
        req = "R2";  cmd(8'h00); adr(8'h10); wr(K_BOTH, 8'h22); adr(8'h20); adr(8'h01);

        req = "R5";  cmd(8'h80); adr(8'hFE); adr(8'h55); adr(8'h02);
        req = "R10"; dat(8'hA1); dat(8'hA2); dat(8'hA3); tick();
        req = "R5";  cmd(8'h10);

        req = "R6";  cmd(8'h60); adr(8'h5C); adr(8'h07); cmd(8'hD0);
        req = "R6";  cmd(8'h60); adr(8'hA3); adr(8'hF9); cmd(8'hD0);

        req = "R7";  cmd(8'h10); cmd(8'hD0);
        cmd(8'h80); adr(8'h11); adr(8'h22); cmd(8'h10);
        cmd(8'h60); adr(8'h33); cmd(8'hD0);
        cmd(8'h80); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'hD0); cmd(8'h10);
        cmd(8'h60); adr(8'h40); adr(8'h01); cmd(8'h10); cmd(8'hD0);

        req = "R8";  busy = 1;
        cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'h90);
        cmd(8'h70); cmd(8'hFF);
        busy = 0; cmd(8'h80); adr(8'h40); adr(8'h41); adr(8'h05);
        busy = 1; dat(8'h99); cmd(8'h10); adr(8'h77);
        busy = 0; dat(8'h5A); dat(8'h5B); cmd(8'h10);
        cmd(8'h60); adr(8'h80); busy = 1; adr(8'h02); busy = 0; adr(8'h03); cmd(8'hD0);

        req = "R9";  cmd(8'h80); adr(8'h10); adr(8'h20); adr(8'h00); dat(8'h01);
        cmd(8'hFF); dat(8'h02); cmd(8'h10);
        cmd(8'h60); adr(8'h10); cmd(8'hFF); adr(8'h20); cmd(8'hD0);
        busy = 1; cmd(8'h80); busy = 0; cmd(8'h00); busy = 1; cmd(8'hFF); busy = 0;
        adr(8'h01); adr(8'h02); adr(8'h03);

        req = "R11"; tick(); tick();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule